// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

The block collects up to 128 level-sensitive interrupt lines, organised as four 32-bit words, and sorts them into 15 priority groups. Each line can be inverted by a polarity bit, gated by an enable bit, and placed into any group through per-group membership masks. A line is pending in a group only when it is active after polarity correction, enabled, and a member of that group. The lowest pending group number always wins. Inside the winning group, the pending line with the highest number (word index times 32 plus bit position) is reported as the top source.

Software uses a simple register port with a combinational read path. Reading the cause register with the read strobe claims the winning group and marks it in service. While any group is in service, only groups with a strictly lower number can raise the interrupt line. Writing a group number to the end-of-service register releases that group. The source must be quiet at its origin before that write. A separate wakeup line reports active lines that are enabled for sleep wake, and pending groups that are enabled for wakeup.

Top module: `gpic_ctrl`

## Requirements
- R1: After reset the word enable (0x00+w), sleep-wake (0x04+w) and membership (0x40+4g+w) registers read zero. Polarity (0x08+w) reads the POL_RESET parameter, which defaults to 0x0000FF00 in word 0 and zero elsewhere. Group mask (0x0D), group wake (0x0F) and global enable (0x10) read zero, and level-select (0x0E) reads 0x7FFF. Cause reads 15, top source reads 0, in-service (0x12) reads 0, and irq_o and wake_o are low.
- R2: A line is active when its input XOR its polarity bit is 1. It is pending in group g only when it is active, its enable bit is 1, and its bit is 1 in group g's membership mask for that word.
- R3: Address 0x80+4g+w returns the pending lines of group g in word w, one bit per line.
- R4: The cause register (0x0C) returns the lowest group number that has a pending line, or 15 when no group has one.
- R5: The top-source register (0x13) returns bit 31 = 1 and bits 6:0 = the highest pending line number in the cause group, or 0 when nothing is pending.
- R6: irq_o rises one clock after these conditions hold, and falls one clock after any of them stops holding. The conditions are: global enable bit 0 is set, and some group g has its bit g set in the group mask, is requesting, and has a number below every in-service group.
- R7: Reading the cause register with reg_rd_i high while a group is pending sets that group's in-service bit (bit g of 0x12). While it is set, groups with an equal or higher number cannot raise irq_o, and lower-numbered groups still can.
- R8: Writing 0x11 clears the in-service bit of the group named in write bits 3:0. A value of 15 changes nothing.
- R9: When level-select bit g is 1, group g requests while it has a pending line. When the bit is 0, the request holds from the first pending cycle until an end-of-service write for g, even after the line goes quiet.
- R10: wake_o is registered and rises when global enable is set and either of two things is true. Either some active line has its sleep-wake bit set, whatever its enable bit, or some pending group has its bit set in the group wake register.
- R11: The enable, sleep-wake, polarity and membership registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 128 | Raw interrupt lines, line n on bit n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Read strobe; on the cause address it claims the winning group |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wakeup request |

## Verification
The bench drives random lines, polarities, enables and sparse memberships, and compares every status, cause and top-source read against a model. A design that scans groups from the wrong end, or lines within a group from the wrong end, reports the wrong cause or top number as soon as two groups or two lines overlap. Directed cases cover several failure modes:
- Claim masking: a faulty design keeps irq_o high for a same-or-higher group, or blocks a strictly lower one.
- End-of-service with value 15: a faulty design clears a wrong bit.
- Held request mode: a faulty design drops irq_o when the line goes quiet.
- Wakeup paths: a faulty design demands the enable bit, or ignores the global enable.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
   localparam int unsigned ADDR_W = 8;
   localparam logic [ADDR_W-1:0] A_EN    = 8'h00;
   localparam logic [ADDR_W-1:0] A_SWAKE = 8'h04;
   localparam logic [ADDR_W-1:0] A_POL   = 8'h08;
   localparam logic [ADDR_W-1:0] A_CAUSE = 8'h0C;
   localparam logic [ADDR_W-1:0] A_GMASK = 8'h0D;
   localparam logic [ADDR_W-1:0] A_LSEL  = 8'h0E;
   localparam logic [ADDR_W-1:0] A_GWAKE = 8'h0F;
   localparam logic [ADDR_W-1:0] A_GLB   = 8'h10;
   localparam logic [ADDR_W-1:0] A_EOS   = 8'h11;
   localparam logic [ADDR_W-1:0] A_INSVC = 8'h12;
   localparam logic [ADDR_W-1:0] A_TOP   = 8'h13;
   localparam logic [ADDR_W-1:0] A_MEMB  = 8'h40;
   localparam logic [ADDR_W-1:0] A_STAT  = 8'h80;
   localparam int unsigned BANK_SLOTS = 4;
endpackage

// File: rtl/gpic_prio_enc.sv
module gpic_prio_enc #(
   parameter int unsigned N          = 15,
   parameter bit          HIGH_FIRST = 1'b0,
   parameter int unsigned IW         = $clog2(N + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [N-1:0]  vec_i,
   output logic [IW-1:0] idx_o,
   output logic          valid_o
);
   if (N < 2) begin : g_bad_n
      $error("gpic_prio_enc: N must be at least 2");
   end
   if ((1 << IW) < N) begin : g_bad_iw
      $error("gpic_prio_enc: IW too narrow for N");
   end

   assign valid_o = |vec_i;

   if (HIGH_FIRST) begin : g_high
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < int'(N); i++) begin
            if (vec_i[i]) idx_o = IW'(i);
         end
      end
      // R5: chosen bit is set and nothing above it
      p_highest_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_o |-> ((vec_i >> idx_o) == N'(1)));
   end else begin : g_low
      always_comb begin
         idx_o = '0;
         for (int i = int'(N) - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
         end
      end
      // R4: chosen bit is set and nothing below it
      p_lowest_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_o |-> (vec_i[idx_o] && (((vec_i >> idx_o) << idx_o) == vec_i)));
   end
endmodule

// File: rtl/gpic_status.sv
module gpic_status #(
   parameter int unsigned NUM_WORDS  = 4,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned NUM_GROUPS = 15
) (
   input  logic [NUM_WORDS-1:0][WORD_W-1:0]                  act_i,
   input  logic [NUM_WORDS-1:0][WORD_W-1:0]                  en_i,
   input  logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0]  memb_i,
   output logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0]  stat_o,
   output logic [NUM_GROUPS-1:0]                             pend_o
);
   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         assign stat_o[g][w] = act_i[w] & en_i[w] & memb_i[g][w];
      end
      assign pend_o[g] = |stat_o[g];
   end
endmodule

// File: rtl/gpic_ctrl.sv
module gpic_ctrl
   import gpic_pkg::*;
#(
   parameter int unsigned NUM_WORDS  = 4,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned NUM_GROUPS = 15,
   parameter logic [NUM_WORDS*WORD_W-1:0] POL_RESET = (NUM_WORDS*WORD_W)'(16'hFF00)
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_WORDS*WORD_W-1:0] src_i,
   input  logic                        reg_wr_i,
   input  logic                        reg_rd_i,
   input  logic [ADDR_W-1:0]           reg_addr_i,
   input  logic [WORD_W-1:0]           reg_wdata_i,
   output logic [WORD_W-1:0]           reg_rdata_o,
   output logic                        irq_o,
   output logic                        wake_o
);
   localparam int unsigned NSRC = NUM_WORDS * WORD_W;
   localparam int unsigned SW   = $clog2(NSRC);
   localparam int unsigned GW   = $clog2(NUM_GROUPS + 1);

   if (NUM_WORDS > BANK_SLOTS) begin : g_bad_words
      $error("gpic_ctrl: NUM_WORDS exceeds register bank slots");
   end
   if (NUM_GROUPS > 16 || NUM_GROUPS < 2) begin : g_bad_groups
      $error("gpic_ctrl: NUM_GROUPS must be 2..16");
   end
   if (WORD_W <= SW || WORD_W < NUM_GROUPS) begin : g_bad_width
      $error("gpic_ctrl: WORD_W too narrow");
   end

   typedef logic [NUM_WORDS-1:0][WORD_W-1:0] bank_t;

   bank_t src_w, act, en_q, sw_q, pol_q;
   logic [NUM_GROUPS-1:0][NUM_WORDS-1:0][WORD_W-1:0] memb_q, stat;
   logic [NUM_GROUPS-1:0] pend, gmask_q, lsel_q, gwake_q, insvc_q, held_q;
   logic [NUM_GROUPS-1:0] req, below, claim_vec, eos_vec;
   logic                  glb_q, irq_q, wake_q;
   logic [GW-1:0]         grp_idx, thr_idx, thr, cause, eos_grp;
   logic                  pend_any, thr_any, top_any, irq_d, wake_d;
   logic [SW-1:0]         top_idx;
   logic [NSRC-1:0]       win_row;

   assign src_w = src_i;
   assign act   = src_w ^ pol_q;

   gpic_status #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .NUM_GROUPS(NUM_GROUPS)) u_status (
      .act_i(act), .en_i(en_q), .memb_i(memb_q), .stat_o(stat), .pend_o(pend));

   gpic_prio_enc #(.N(NUM_GROUPS), .HIGH_FIRST(1'b0), .IW(GW)) u_grp_enc (
      .clk_i(clk_i), .rst_ni(rst_ni), .vec_i(pend), .idx_o(grp_idx), .valid_o(pend_any));

   gpic_prio_enc #(.N(NUM_GROUPS), .HIGH_FIRST(1'b0), .IW(GW)) u_thr_enc (
      .clk_i(clk_i), .rst_ni(rst_ni), .vec_i(insvc_q), .idx_o(thr_idx), .valid_o(thr_any));

   assign win_row = stat[grp_idx];

   gpic_prio_enc #(.N(NSRC), .HIGH_FIRST(1'b1), .IW(SW)) u_top_enc (
      .clk_i(clk_i), .rst_ni(rst_ni), .vec_i(win_row), .idx_o(top_idx), .valid_o(top_any));

   assign cause   = pend_any ? grp_idx : GW'(NUM_GROUPS);
   assign thr     = thr_any ? thr_idx : GW'(NUM_GROUPS);
   assign eos_grp = reg_wdata_i[GW-1:0];

   always_comb begin
      claim_vec = '0;
      eos_vec   = '0;
      if (reg_rd_i && reg_addr_i == A_CAUSE && pend_any) claim_vec[grp_idx] = 1'b1;
      if (reg_wr_i && reg_addr_i == A_EOS && int'(eos_grp) < int'(NUM_GROUPS))
         eos_vec[eos_grp] = 1'b1;
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_req
      assign req[g]   = lsel_q[g] ? pend[g] : (pend[g] | held_q[g]);
      assign below[g] = GW'(g) < thr;
   end

   assign irq_d  = glb_q & |(req & gmask_q & below);
   assign wake_d = glb_q & ((|(act & sw_q)) | (|(pend & gwake_q)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q    <= '0;
         sw_q    <= '0;
         pol_q   <= POL_RESET;
         memb_q  <= '0;
         gmask_q <= '0;
         lsel_q  <= '1;
         gwake_q <= '0;
         glb_q   <= 1'b0;
         insvc_q <= '0;
         held_q  <= '0;
         irq_q   <= 1'b0;
         wake_q  <= 1'b0;
      end else begin
         for (int w = 0; w < int'(NUM_WORDS); w++) begin
            if (reg_wr_i && reg_addr_i == A_EN + ADDR_W'(w))    en_q[w]  <= reg_wdata_i;
            if (reg_wr_i && reg_addr_i == A_SWAKE + ADDR_W'(w)) sw_q[w]  <= reg_wdata_i;
            if (reg_wr_i && reg_addr_i == A_POL + ADDR_W'(w))   pol_q[w] <= reg_wdata_i;
            for (int g = 0; g < int'(NUM_GROUPS); g++) begin
               if (reg_wr_i && reg_addr_i == A_MEMB + ADDR_W'(BANK_SLOTS * g + w))
                  memb_q[g][w] <= reg_wdata_i;
            end
         end
         if (reg_wr_i && reg_addr_i == A_GMASK) gmask_q <= reg_wdata_i[NUM_GROUPS-1:0];
         if (reg_wr_i && reg_addr_i == A_LSEL)  lsel_q  <= reg_wdata_i[NUM_GROUPS-1:0];
         if (reg_wr_i && reg_addr_i == A_GWAKE) gwake_q <= reg_wdata_i[NUM_GROUPS-1:0];
         if (reg_wr_i && reg_addr_i == A_GLB)   glb_q   <= reg_wdata_i[0];
         insvc_q <= (insvc_q | claim_vec) & ~eos_vec;
         held_q  <= (held_q | pend) & ~eos_vec;
         irq_q   <= irq_d;
         wake_q  <= wake_d;
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      for (int w = 0; w < int'(NUM_WORDS); w++) begin
         if (reg_addr_i == A_EN + ADDR_W'(w))    reg_rdata_o = en_q[w];
         if (reg_addr_i == A_SWAKE + ADDR_W'(w)) reg_rdata_o = sw_q[w];
         if (reg_addr_i == A_POL + ADDR_W'(w))   reg_rdata_o = pol_q[w];
         for (int g = 0; g < int'(NUM_GROUPS); g++) begin
            if (reg_addr_i == A_MEMB + ADDR_W'(BANK_SLOTS * g + w)) reg_rdata_o = memb_q[g][w];
            if (reg_addr_i == A_STAT + ADDR_W'(BANK_SLOTS * g + w)) reg_rdata_o = stat[g][w];
         end
      end
      if (reg_addr_i == A_CAUSE) reg_rdata_o = WORD_W'(cause);
      if (reg_addr_i == A_GMASK) reg_rdata_o = WORD_W'(gmask_q);
      if (reg_addr_i == A_LSEL)  reg_rdata_o = WORD_W'(lsel_q);
      if (reg_addr_i == A_GWAKE) reg_rdata_o = WORD_W'(gwake_q);
      if (reg_addr_i == A_GLB)   reg_rdata_o = WORD_W'(glb_q);
      if (reg_addr_i == A_INSVC) reg_rdata_o = WORD_W'(insvc_q);
      if (reg_addr_i == A_TOP) begin
         reg_rdata_o[WORD_W-1] = top_any;
         reg_rdata_o[SW-1:0]   = top_idx;
      end
   end

   assign irq_o  = irq_q;
   assign wake_o = wake_q;

   // R7: a claim without a same-cycle release leaves the group in service
   p_claim_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((claim_vec & ~eos_vec) != '0) |=>
      ((insvc_q & $past(claim_vec & ~eos_vec)) == $past(claim_vec & ~eos_vec)));
   // R8: a release empties the named in-service bit
   p_eos_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eos_vec != '0) |=> ((insvc_q & $past(eos_vec)) == '0));
   // R6: no request one cycle after the global enable was clear
   p_irq_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !glb_q |=> !irq_o);
   // R10: same gating for the wakeup line
   p_wake_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !glb_q |=> !wake_o);
endmodule

// File: tb/gpic_ctrl_test.sv
module gpic_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] src = '0;
   logic         wr = 1'b0, rd = 1'b0;
   logic [7:0]   addr = '0;
   logic [31:0]  wdata = '0, rdata;
   logic         irq, wake;

   int n_chk = 0, n_fail = 0;

   logic [31:0] m_en [4], m_sw [4], m_pol [4];
   logic [31:0] m_memb [15][4];
   logic [14:0] m_gmask, m_gwake;
   logic        m_glb;

   gpic_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_wr_i(wr), .reg_rd_i(rd),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .irq_o(irq), .wake_o(wake));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic model_clear();
      for (int w = 0; w < 4; w++) begin
         m_en[w] = '0; m_sw[w] = '0; m_pol[w] = (w == 0) ? 32'h0000_FF00 : '0;
         for (int g = 0; g < 15; g++) m_memb[g][w] = '0;
      end
      m_gmask = '0; m_gwake = '0; m_glb = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; src = '0; wr = 1'b0; rd = 1'b0;
      model_clear();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_reg(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      if (a < 8'h04) m_en[a[1:0]] = d;
      else if (a < 8'h08) m_sw[a[1:0]] = d;
      else if (a < 8'h0C) m_pol[a[1:0]] = d;
      else if (a == 8'h0D) m_gmask = d[14:0];
      else if (a == 8'h0F) m_gwake = d[14:0];
      else if (a == 8'h10) m_glb = d[0];
      else if (a >= 8'h40 && a < 8'h7C) m_memb[(a - 8'h40) / 4][a[1:0]] = d;
      @(posedge clk); #1;
      wr = 1'b0;
   endtask

   task automatic rd_reg(logic [7:0] a, bit strobe, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd = strobe;
      #1 d = rdata;
      @(posedge clk); #1;
      rd = 1'b0;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [31:0] e_stat(int g, int w);
      return (src[w*32 +: 32] ^ m_pol[w]) & m_en[w] & m_memb[g][w];
   endfunction

   function automatic bit e_pend(int g);
      for (int w = 0; w < 4; w++) if (e_stat(g, w) != 0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int e_cause();
      for (int g = 0; g < 15; g++) if (e_pend(g)) return g;
      return 15;
   endfunction

   function automatic logic [31:0] e_top();
      int c = e_cause();
      logic [31:0] row;
      if (c == 15) return 32'h0;
      for (int s = 127; s >= 0; s--) begin
         row = e_stat(c, s / 32);
         if (row[s % 32]) return 32'h8000_0000 | 32'(s);
      end
      return 32'h0;
   endfunction

   function automatic logic e_irq();
      for (int g = 0; g < 15; g++) if (e_pend(g) && m_gmask[g]) return m_glb;
      return 1'b0;
   endfunction

   function automatic logic e_wake();
      bit any = 1'b0;
      for (int w = 0; w < 4; w++) if (((src[w*32 +: 32] ^ m_pol[w]) & m_sw[w]) != 0) any = 1'b1;
      for (int g = 0; g < 15; g++) if (e_pend(g) && m_gwake[g]) any = 1'b1;
      return m_glb & any;
   endfunction

   logic [31:0] d;

   initial begin
      void'($urandom(32'd2718));
      model_clear();
      do_reset();

      // R1: reset values
      for (int w = 0; w < 4; w++) begin
         rd_reg(8'(w), 0, d);        chk("R1", "enable", d, 32'h0);
         rd_reg(8'(4 + w), 0, d);    chk("R1", "sleep-wake", d, 32'h0);
         rd_reg(8'(8 + w), 0, d);    chk("R1", "polarity", d, (w == 0) ? 32'h0000_FF00 : 32'h0);
      end
      rd_reg(8'h40, 0, d); chk("R1", "membership g0w0", d, 32'h0);
      rd_reg(8'h7B, 0, d); chk("R1", "membership g14w3", d, 32'h0);
      rd_reg(8'h0E, 0, d); chk("R1", "level-select", d, 32'h7FFF);
      rd_reg(8'h10, 0, d); chk("R1", "global enable", d, 32'h0);
      rd_reg(8'h0C, 0, d); chk("R1", "cause", d, 32'd15);
      rd_reg(8'h13, 0, d); chk("R1", "top", d, 32'h0);
      rd_reg(8'h12, 0, d); chk("R1", "in-service", d, 32'h0);
      chk("R1", "irq_o", 32'(irq), 32'h0);
      chk("R1", "wake_o", 32'(wake), 32'h0);

      // R2 R3: polarity correction on word 0 bit 8 (inverted by default)
      wr_reg(8'h40 + 8'd12, 32'h0000_0100);   // group 3 word 0
      wr_reg(8'h00, 32'h0000_0100);
      src = '0; settle();
      rd_reg(8'h80 + 8'd12, 0, d); chk("R2", "inverted low line pending", d, 32'h0000_0100);
      src[8] = 1'b1; settle();
      rd_reg(8'h80 + 8'd12, 0, d); chk("R2", "inverted high line quiet", d, 32'h0);
      wr_reg(8'h00, 32'h0);
      src[8] = 1'b0; settle();
      rd_reg(8'h80 + 8'd12, 0, d); chk("R2", "disabled line quiet", d, 32'h0);

      // R11: readback
      wr_reg(8'h06, 32'hA5A5_0F0F); rd_reg(8'h06, 0, d); chk("R11", "sleep-wake w2", d, 32'hA5A5_0F0F);
      wr_reg(8'h45, 32'h1234_5678); rd_reg(8'h45, 0, d); chk("R11", "membership g1w1", d, 32'h1234_5678);
      wr_reg(8'h0B, 32'hDEAD_BEEF); rd_reg(8'h0B, 0, d); chk("R11", "polarity w3", d, 32'hDEAD_BEEF);

      // R4 R5 R6 R7 R8: claim and release
      do_reset();
      for (int w = 0; w < 4; w++) wr_reg(8'(w), 32'hFFFF_FFFF);
      wr_reg(8'h40 + 8'd20, 32'h0000_0008);   // group 5 word 0 line 3
      wr_reg(8'h40 + 8'd22, 32'h0000_0040);   // group 5 word 2 line 70
      wr_reg(8'h40 + 8'd39, 32'h0000_0010);   // group 9 word 3 line 100
      wr_reg(8'h40 + 8'd9,  32'h0000_0100);   // group 2 word 1 line 40
      wr_reg(8'h0D, 32'h7FFF);
      src = '0; src[3] = 1'b1; src[70] = 1'b1; src[100] = 1'b1;
      settle();
      chk("R6", "irq low while global disabled", 32'(irq), 32'h0);
      wr_reg(8'h10, 32'h1); settle();
      chk("R6", "irq high when enabled", 32'(irq), 32'h1);
      rd_reg(8'h13, 0, d); chk("R5", "top is line 70", d, 32'h8000_0046);
      rd_reg(8'h0C, 1, d); chk("R4", "claimed cause", d, 32'd5);
      rd_reg(8'h12, 0, d); chk("R7", "in-service after claim", d, 32'h0000_0020);
      settle();
      chk("R7", "irq blocked for groups 5 and 9", 32'(irq), 32'h0);
      src[40] = 1'b1; settle();
      chk("R7", "lower group 2 still raises", 32'(irq), 32'h1);
      rd_reg(8'h0C, 0, d); chk("R4", "cause group 2", d, 32'd2);
      wr_reg(8'h11, 32'd15); rd_reg(8'h12, 0, d);
      chk("R8", "release of 15 ignored", d, 32'h0000_0020);
      src[40] = 1'b0;
      wr_reg(8'h11, 32'd5); rd_reg(8'h12, 0, d);
      chk("R8", "release of group 5", d, 32'h0);
      settle();
      chk("R6", "irq back after release", 32'(irq), 32'h1);
      wr_reg(8'h0D, 32'h7FDF); settle();   // mask group 5, group 9 still open
      chk("R6", "group 9 alone raises", 32'(irq), 32'h1);
      wr_reg(8'h0D, 32'h5DDF); settle();
      chk("R6", "all pending groups masked", 32'(irq), 32'h0);

      // R9: held request mode
      do_reset();
      wr_reg(8'h40 + 8'd16, 32'h0000_0004);   // group 4 word 0 line 2
      wr_reg(8'h00, 32'h0000_0004);
      wr_reg(8'h0D, 32'h0010);
      wr_reg(8'h0E, 32'h7FEF);
      wr_reg(8'h10, 32'h1);
      src[2] = 1'b1; settle();
      chk("R9", "held group raises", 32'(irq), 32'h1);
      src[2] = 1'b0; settle();
      chk("R9", "held after line quiet", 32'(irq), 32'h1);
      wr_reg(8'h11, 32'd4); settle();
      chk("R9", "released by end-of-service", 32'(irq), 32'h0);
      wr_reg(8'h0E, 32'h7FFF);
      src[2] = 1'b1; settle(); src[2] = 1'b0; settle();
      chk("R9", "level mode follows line", 32'(irq), 32'h0);

      // R10: wake paths
      do_reset();
      wr_reg(8'h05, 32'h0000_0001);          // line 32 sleep-wake, not enabled
      src[32] = 1'b1; settle();
      chk("R10", "wake gated by global", 32'(wake), 32'h0);
      wr_reg(8'h10, 32'h1); settle();
      chk("R10", "wake without enable bit", 32'(wake), 32'h1);
      chk("R10", "no irq from unenabled line", 32'(irq), 32'h0);
      wr_reg(8'h05, 32'h0); settle();
      chk("R10", "wake off", 32'(wake), 32'h0);
      wr_reg(8'h01, 32'h0000_0001); wr_reg(8'h44 + 8'd1, 32'h0000_0001); // group 1 word 1
      wr_reg(8'h0F, 32'h0002); settle();
      chk("R10", "group wake path", 32'(wake), 32'h1);

      // R2 R3 R4 R5 R6 R10: random phase
      do_reset();
      for (int it = 0; it < 80; it++) begin
         for (int k = 0; k < 4; k++) begin
            int sel = $urandom_range(0, 6);
            int w = $urandom_range(0, 3);
            int g = $urandom_range(0, 14);
            case (sel)
               0: wr_reg(8'(w), $urandom);
               1: wr_reg(8'(4 + w), $urandom & $urandom & $urandom);
               2: wr_reg(8'(8 + w), $urandom);
               3: wr_reg(8'h40 + 8'(4 * g + w), $urandom & $urandom & $urandom);
               4: wr_reg(8'h0D, $urandom);
               5: wr_reg(8'h0F, $urandom & $urandom);
               default: wr_reg(8'h10, 32'($urandom_range(0, 3) != 0));
            endcase
         end
         @(negedge clk);
         for (int w = 0; w < 4; w++) src[w*32 +: 32] = $urandom & $urandom;
         settle();
         rd_reg(8'h0C, 0, d); chk("R4", "random cause", d, 32'(e_cause()));
         rd_reg(8'h13, 0, d); chk("R5", "random top", d, e_top());
         chk("R6", "random irq", 32'(irq), 32'(e_irq()));
         chk("R10", "random wake", 32'(wake), 32'(e_wake()));
         for (int k = 0; k < 3; k++) begin
            int g = $urandom_range(0, 14);
            int w = $urandom_range(0, 3);
            rd_reg(8'h80 + 8'(4 * g + w), 0, d);
            chk("R3", "random status", d, e_stat(g, w));
         end
      end
      summary();
   end
endmodule